// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block builds an outgoing frame from one or more segments and fills in a 16-bit ones'-complement Internet checksum before the frame leaves. Each segment starts with a 32-bit control word, followed by exactly the number of payload bytes that the word announces. The bytes go into an assembly buffer of 2048 bytes at increasing frame positions. While they arrive, a running sum is kept over the bytes that lie at or after a start position. The start position comes from the first segment of the frame.

When the last segment of the frame has been consumed, the engine folds the sum and inverts it. If that segment asks for a checksum, the engine writes the result into the buffer at the stuff position, high byte first. It then pulses `done` with the frame length, the inserted checksum and a flag that says whether the frame may be sent. For each segment it returns a status word, which is the control word with its ownership bit cleared. The buffer contents can be read back through a separate address port.

Top module: `tx_csum_insert`

## Requirements
- R1: The control word is decoded as follows: bit 31 is ownership, bit 30 is start-of-frame, bit 29 is end-of-frame, bit 28 is checksum-enable, bits 27..20 are the stuff position, bits 19..14 are the start position and bits 12..0 are the segment length in bytes. The stream must then supply exactly that many bytes.
- R2: A segment with start-of-frame set clears the running sum and latches the start and stuff positions, which then apply to the whole frame.
- R3: Only bytes at a frame position greater than or equal to the start position, and only bytes of segments with checksum-enable set, are added to the sum. All other bytes are stored but not added.
- R4: Bytes that would land at position 2048 or higher are consumed but discarded. The reported frame length saturates at 2048.
- R5: The sum pairs bytes by absolute frame position: a byte at an even position is the high byte of a 16-bit word and a byte at an odd position is the low byte. This holds across segment boundaries and for segments of odd length.
- R6: At end-of-frame with checksum-enable set on that segment, the carries are folded back into a 16-bit value, the value is inverted, and the result is written at the stuff position (high byte) and at the stuff position plus one (low byte). The same value appears on `csum_out`.
- R7: After the last byte of each segment (or at once for a zero-length segment), `status_valid` pulses for one cycle, and `status_word` equals the control word with bit 31 cleared.
- R8: If the end-of-frame segment has checksum-enable clear, the buffer is not patched and `csum_out` is 0. `frame_sent` in the `done` cycle equals `tx_enable`. Position counting restarts at 0 after `done`.
- R9: After reset the engine accepts a control word and asserts neither `done` nor `status_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Control word offered |
| desc_word | input | 32 | Segment control word |
| desc_ready | output | 1 | Engine can accept a control word |
| byte_valid | input | 1 | Payload byte offered |
| byte_data | input | 8 | Payload byte |
| byte_ready | output | 1 | Engine can accept a payload byte |
| tx_enable | input | 1 | Transmit permission, sampled at end of frame |
| status_valid | output | 1 | Segment consumed pulse |
| status_word | output | 32 | Returned segment status |
| done | output | 1 | Frame complete pulse |
| frame_len | output | 12 | Frame length in bytes, valid with done |
| csum_out | output | 16 | Inserted checksum, valid with done |
| frame_sent | output | 1 | Frame released for transmission, valid with done |
| rd_addr | input | 11 | Buffer read address |
| rd_data | output | 8 | Buffer byte at rd_addr |

## Verification
The bench sweeps the start position across a two-segment frame whose first segment has odd length. A design that paired bytes by their position in the segment rather than in the frame would get the checksum wrong on every step of that sweep, and a design with an off-by-one in the start comparison would go wrong at the sweep boundaries. Further frames mix enabled and disabled segments, end on a segment that has no checksum, and run past the 2048-byte limit with a final zero-length segment. These catch a design that sums excluded bytes, patches the buffer when it should not, lets the length or the stored bytes spill past the buffer, or misses the status pulse of an empty segment. After every frame the whole buffer is compared against a model, so a swapped byte order at the stuff position shows up directly.

// File: rtl/tx_csum_insert.sv
module tx_csum_insert #(
  parameter int BUF_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        desc_valid,
  input  logic [31:0] desc_word,
  output logic        desc_ready,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  output logic        byte_ready,
  input  logic        tx_enable,
  output logic        status_valid,
  output logic [31:0] status_word,
  output logic        done,
  output logic [11:0] frame_len,
  output logic [15:0] csum_out,
  output logic        frame_sent,
  input  logic [10:0] rd_addr,
  output logic [7:0]  rd_data
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int PW = AW + 1;

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_SEGEND, S_HI, S_LO, S_FIN} state_t;
  state_t state;

  logic [7:0]    mem [BUF_BYTES];
  logic [31:0]   desc_q;
  logic [12:0]   left;
  logic [PW-1:0] pos;
  logic [31:0]   acc;
  logic [5:0]    start_q;
  logic [7:0]    stuff_q;
  logic [15:0]   csum_q;
  logic [16:0]   f1;
  logic [15:0]   f2, fold;
  logic          take, room, in_sum;

  assign desc_ready   = state == S_IDLE;
  assign byte_ready   = state == S_DATA;
  assign status_valid = state == S_SEGEND;
  assign status_word  = {1'b0, desc_q[30:0]};
  assign done         = state == S_FIN;
  assign frame_len    = 12'(pos);
  assign csum_out     = csum_q;
  assign frame_sent   = done & tx_enable;
  assign rd_data      = mem[rd_addr[AW-1:0]];

  assign take   = byte_valid && state == S_DATA;
  assign room   = pos < PW'(BUF_BYTES);
  assign in_sum = desc_q[28] && pos >= PW'(start_q);
  assign f1     = {1'b0, acc[15:0]} + {1'b0, acc[31:16]};
  assign f2     = f1[15:0] + {15'b0, f1[16]};
  assign fold   = ~f2;

  always_ff @(posedge clk) begin
    if (take && room) mem[pos[AW-1:0]] <= byte_data;
    else if (state == S_HI) mem[AW'(stuff_q)] <= fold[15:8];
    else if (state == S_LO) mem[AW'(stuff_q) + AW'(1)] <= csum_q[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      desc_q  <= '0;
      left    <= '0;
      pos     <= '0;
      acc     <= '0;
      start_q <= '0;
      stuff_q <= '0;
      csum_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (desc_valid) begin
          desc_q <= desc_word;
          left   <= desc_word[12:0];
          if (desc_word[30]) begin
            acc     <= '0;
            start_q <= desc_word[19:14];
            stuff_q <= desc_word[27:20];
          end
          state <= (desc_word[12:0] == 13'd0) ? S_SEGEND : S_DATA;
        end
        S_DATA: if (take) begin
          if (room) begin
            pos <= pos + PW'(1);
            if (in_sum) acc <= acc + (pos[0] ? {24'b0, byte_data} : {16'b0, byte_data, 8'b0});
          end
          left <= left - 13'd1;
          if (left == 13'd1) state <= S_SEGEND;
        end
        S_SEGEND: begin
          if (!desc_q[29]) state <= S_IDLE;
          else if (desc_q[28]) state <= S_HI;
          else begin
            csum_q <= '0;
            state  <= S_FIN;
          end
        end
        S_HI: begin
          csum_q <= fold;
          state  <= S_LO;
        end
        S_LO: state <= S_FIN;
        default: begin
          pos   <= '0;
          state <= S_IDLE;
        end
      endcase
    end
  end

  assert_pos_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= PW'(BUF_BYTES));
  assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !room) |=> $stable(pos));
  assert_own_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> !status_word[31]);
  assert_sop_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_ready && desc_valid && desc_word[30]) |=> acc == 32'd0);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && pos == '0));
  assert_nocsum_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !desc_q[28]) |-> csum_out == 16'd0);
endmodule

// File: tb/tx_csum_insert_bench.sv
module tx_csum_insert_bench;
  logic clk = 0, rst_n = 0;
  logic desc_valid = 0, byte_valid = 0, tx_enable = 0;
  logic [31:0] desc_word = '0;
  logic [7:0] byte_data = '0;
  logic [10:0] rd_addr = '0;
  logic desc_ready, byte_ready, status_valid, done, frame_sent;
  logic [31:0] status_word;
  logic [11:0] frame_len;
  logic [15:0] csum_out;
  logic [7:0] rd_data;

  int errors = 0, checks = 0;
  logic [7:0] ref_mem [2048];
  int m_pos = 0, m_start = 0, m_stuff = 0;
  longint m_sum = 0;

  always #10 clk = ~clk;

  tx_csum_insert u_tx_csum_insert (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_word(desc_word),
    .desc_ready(desc_ready), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .tx_enable(tx_enable), .status_valid(status_valid),
    .status_word(status_word), .done(done), .frame_len(frame_len),
    .csum_out(csum_out), .frame_sent(frame_sent), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fold_sum(input longint s);
    longint t = s;
    while (t >> 16 != 0) t = (t & 16'hffff) + (t >> 16);
    return ~t[15:0];
  endfunction

  task automatic seg(input bit sop, input bit eop, input bit ce, input int stuff,
                     input int start, input int len, input int seed);
    logic [31:0] w;
    w = {1'b1, sop, eop, ce, 8'(stuff), 6'(start), 1'b0, 13'(len)};
    if (sop) begin m_sum = 0; m_start = start; m_stuff = stuff; end
    while (!desc_ready) @(negedge clk);
    desc_valid = 1; desc_word = w;
    @(negedge clk);
    desc_valid = 0;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'(seed * 37 + m_pos * 13 + i + 5);
      while (!byte_ready) @(negedge clk);
      byte_valid = 1; byte_data = b;
      if (m_pos < 2048) begin
        ref_mem[m_pos] = b;
        if (ce && m_pos >= m_start) m_sum += (m_pos % 2 == 1) ? longint'(b) : longint'(b) << 8;
        m_pos++;
      end
      @(negedge clk);
    end
    byte_valid = 0;
    check("R7 status pulse", status_valid, 1);
    check("R7 status word", status_word, {1'b0, w[30:0]});
  endtask

  task automatic finish_frame(input bit ce, input string req);
    logic [15:0] exp_c;
    int bad;
    exp_c = ce ? fold_sum(m_sum) : 16'h0;
    if (ce) begin
      ref_mem[m_stuff] = exp_c[15:8];
      ref_mem[m_stuff + 1] = exp_c[7:0];
    end
    for (int k = 0; k < 8 && !done; k++) @(negedge clk);
    check({req, " done"}, done, 1);
    check({req, " frame_len R4"}, frame_len, m_pos);
    check({req, " csum R6"}, csum_out, exp_c);
    check({req, " sent R8"}, frame_sent, tx_enable);
    @(negedge clk);
    bad = 0;
    for (int a = 0; a < 2048; a++) begin
      rd_addr = 11'(a);
      #0.1;
      if (rd_data !== ref_mem[a]) bad++;
    end
    check({req, " buffer R6"}, bad, 0);
    m_pos = 0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 2048; a++) ref_mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 desc_ready", desc_ready, 1);
    check("R9 done", done, 0);
    check("R9 status", status_valid, 0);
    // preload buffer to a known state
    tx_enable = 1;
    seg(1, 1, 0, 0, 0, 300, 99);
    finish_frame(0, "R1 preload");
    // R1 R6: single segment
    seg(1, 1, 1, 10, 0, 20, 1);
    finish_frame(1, "R1 single");
    // R2 R3 R5: start sweep, odd first segment
    for (int st = 0; st < 10; st++) begin
      seg(1, 0, 1, 30, st, 7, st + 2);
      seg(0, 1, 1, 30, 63, 12, st + 3);
      finish_frame(1, "R5 sweep");
    end
    // R3: middle segment without checksum
    seg(1, 0, 1, 2, 4, 9, 20);
    seg(0, 0, 0, 200, 0, 11, 21);
    seg(0, 1, 1, 200, 0, 6, 22);
    finish_frame(1, "R3 mixed");
    // R8: no checksum on last segment, tx disabled
    tx_enable = 0;
    seg(1, 0, 1, 3, 0, 10, 30);
    seg(0, 1, 0, 3, 0, 5, 31);
    finish_frame(0, "R8 nocsum");
    // R2: sum restarts at new frame, R8 position restart
    tx_enable = 1;
    seg(1, 1, 1, 40, 2, 15, 40);
    finish_frame(1, "R2 restart");
    // R4: truncation with trailing empty segment
    seg(1, 0, 1, 4, 14, 1500, 50);
    seg(0, 0, 1, 4, 0, 601, 51);
    seg(0, 1, 1, 4, 0, 0, 52);
    finish_frame(1, "R4 trunc");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule